// File: doc/BRIEF.md
# Descriptor-chained frame extraction channel

This block moves received frames from a byte stream into memory. Software builds a linked list of descriptors, and each descriptor names one data buffer. The channel starts at the list head and receives exactly one frame into the current descriptor's buffer. When the frame ends, it writes the stored length and completion flags back into the descriptor and then follows the descriptor's link to the next one. A link value of 0x1 marks the end of the chain. At that point the channel parks and holds the stream back until software appends a descriptor and issues a reload.

Each descriptor is four 32-bit words at byte offsets from its base. Offset 0 is the link to the next descriptor. Offset 4 is the info word, whose bits 15:0 give the buffer capacity in bytes. Offset 8 is the buffer's byte address. Offset 12 is the status word. Memory is reached through one byte-addressed, 32-bit port with byte enables and no wait states. Read data returns one cycle after the request.

Top module: `xtr_dma_chan`

## Requirements
- R1: On a `cmd_activate` pulse while inactive, the channel loads the descriptor at `head_addr`, and the first frame lands in that descriptor's buffer.
- R2: Byte k of a frame is written to byte address (buffer address + k) for every k below the capacity in info bits 15:0, and to no other buffer location.
- R3: At end of frame the status word is rewritten as follows: bits 15:0 hold the stored byte count; bits 16 (start), 17 (end) and 19 (done) are 1; bit 18 keeps the value software left there; bits 31:20 are 0.
- R4: Bytes beyond the capacity are accepted and dropped, so the stored count is the capacity. A truncated frame sets `irq_err`, which stays high until `err_ack`.
- R5: When a link reads 0x1, the channel stalls. `s_ready` stays low and nothing is written. A `cmd_reload`, even one issued before the stall, makes the channel re-read the same link and continue.
- R6: A completed descriptor whose status bit 18 was 1 sets `irq_db` when `int_en` is 1. The flag is sticky until `int_ack`. With `int_en` at 0 no flag is raised.
- R7: `chan_active` is high from activation until the channel stops. After `cmd_disable` it stays high while a frame is in progress, and falls once the frame's status is written, or at a stall or an empty receive wait. While inactive the memory port is idle.
- R8: A `cmd_discard` pulse while inactive makes the channel accept and drop stream beats up to and including one with `s_last`, with no memory access. `s_ready` then returns low.
- R9: After reset, `chan_active`, `s_ready`, `mem_req`, `irq_db` and `irq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_addr | input | AW | Byte address of the first descriptor |
| cmd_activate | input | 1 | Pulse: start at the list head |
| cmd_reload | input | 1 | Pulse: re-read the end-of-chain link |
| cmd_disable | input | 1 | Pulse: stop at the next frame boundary |
| cmd_discard | input | 1 | Pulse: drop one incoming frame while inactive |
| int_en | input | 1 | Enable for the per-descriptor completion flag |
| int_ack | input | 1 | Clears the completion flag |
| err_ack | input | 1 | Clears the truncation flag |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of a frame |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| chan_active | output | 1 | Channel running |
| irq_db | output | 1 | Sticky descriptor-completion interrupt |
| irq_err | output | 1 | Sticky truncation interrupt |

## Verification
The hardest state to reach is the end-of-chain stall with a frame already waiting. The channel only reaches it when software stops appending descriptors, and a reload sent too early must not be lost. The bench sweeps frame lengths from below to above a small capacity over a two-descriptor ring that it relinks after every frame. In the final iteration it pulses reload without adding a link. The next frame then drives the channel onto a 0x1 link with the pending reload already consumed. While the next frame's first byte is held on the stream, the bench checks that `s_ready` stays low and that no descriptor changes. Only then does it link and reload. Disable during a frame is reached by pausing the stream halfway through that frame.

// File: rtl/xtr_dma_pkg.sv
package xtr_dma_pkg;
   localparam int LEN_W      = 16;
   localparam int SOF_BIT    = 16;
   localparam int EOF_BIT    = 17;
   localparam int IRQ_BIT    = 18;
   localparam int DONE_BIT   = 19;
   localparam logic [31:0] LINK_END = 32'h1;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_CAPT, ST_RECV, ST_WRST, ST_STALL, ST_DRAIN
   } xtr_state_t;

   // word index times four is the byte offset inside a descriptor
   typedef enum logic [1:0] {
      W_LINK = 2'd0, W_INFO = 2'd1, W_BUF = 2'd2, W_STAT = 2'd3
   } xtr_word_t;
endpackage

// File: rtl/xtr_desc_ctrl.sv
module xtr_desc_ctrl
   import xtr_dma_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    head_addr,
   input  logic             cmd_activate,
   input  logic             cmd_reload,
   input  logic             cmd_disable,
   input  logic             cmd_discard,
   input  logic             s_valid,
   input  logic [7:0]       s_data,
   input  logic             s_last,
   output logic             s_ready,
   input  logic [31:0]      rd_data,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   output logic             wr_byte,
   output logic             wr_word,
   output logic [AW-1:0]    wr_addr,
   output logic [7:0]       wr_data8,
   output logic [31:0]      wr_data32,
   output logic             chan_active,
   output logic             stalled,
   output logic             blk_done,
   output logic             blk_irq,
   output logic             blk_trunc,
   output logic [AW-1:0]    dptr_q,
   output logic [LEN_W-1:0] cap_q
);
   xtr_state_t       state_q;
   xtr_word_t        widx_q;
   logic [AW-1:0]    cur_q;
   logic [LEN_W-1:0] cnt_q;
   logic             irqb_q, trunc_q, started_q, dis_pend_q, rel_pend_q;
   logic             room, take;

   assign room        = cnt_q < cap_q;
   assign take        = (state_q == ST_RECV) && s_valid;
   assign s_ready     = (state_q == ST_RECV) || (state_q == ST_DRAIN);
   assign chan_active = (state_q != ST_IDLE) && (state_q != ST_DRAIN);
   assign stalled     = (state_q == ST_STALL);

   assign rd_req    = (state_q == ST_FETCH);
   assign rd_addr   = cur_q + AW'({widx_q, 2'b00});
   assign wr_byte   = take && room;
   assign wr_word   = (state_q == ST_WRST);
   assign wr_addr   = wr_word ? cur_q + AW'({W_STAT, 2'b00}) : dptr_q + AW'(cnt_q);
   assign wr_data8  = s_data;
   assign wr_data32 = {12'd0, 1'b1, irqb_q, 1'b1, 1'b1, cnt_q};

   assign blk_done  = wr_word;
   assign blk_irq   = irqb_q;
   assign blk_trunc = trunc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         widx_q     <= W_INFO;
         cur_q      <= '0;
         dptr_q     <= '0;
         cap_q      <= '0;
         cnt_q      <= '0;
         irqb_q     <= 1'b0;
         trunc_q    <= 1'b0;
         started_q  <= 1'b0;
         dis_pend_q <= 1'b0;
         rel_pend_q <= 1'b0;
      end else begin
         // a pending reload is consumed by the next link read
         if (state_q == ST_FETCH && widx_q == W_LINK) rel_pend_q <= 1'b0;
         if (cmd_reload) rel_pend_q <= 1'b1;

         if (!chan_active) dis_pend_q <= 1'b0;
         else if (cmd_disable) dis_pend_q <= 1'b1;

         unique case (state_q)
            ST_IDLE: begin
               if (cmd_activate) begin
                  cur_q   <= head_addr;
                  widx_q  <= W_INFO;
                  state_q <= ST_FETCH;
               end else if (cmd_discard) begin
                  state_q <= ST_DRAIN;
               end
            end
            ST_FETCH: state_q <= ST_CAPT;
            ST_CAPT: begin
               state_q <= ST_FETCH;
               unique case (widx_q)
                  W_INFO: begin
                     cap_q  <= rd_data[LEN_W-1:0];
                     widx_q <= W_BUF;
                  end
                  W_BUF: begin
                     dptr_q <= rd_data[AW-1:0];
                     widx_q <= W_STAT;
                  end
                  W_STAT: begin
                     irqb_q    <= rd_data[IRQ_BIT];
                     cnt_q     <= '0;
                     trunc_q   <= 1'b0;
                     started_q <= 1'b0;
                     state_q   <= ST_RECV;
                  end
                  W_LINK: begin
                     if (rd_data == LINK_END) begin
                        state_q <= ST_STALL;
                     end else begin
                        cur_q  <= rd_data[AW-1:0];
                        widx_q <= W_INFO;
                     end
                  end
               endcase
            end
            ST_RECV: begin
               if (take) begin
                  started_q <= 1'b1;
                  if (room) cnt_q <= cnt_q + 1'b1;
                  else      trunc_q <= 1'b1;
                  if (s_last) state_q <= ST_WRST;
               end else if (dis_pend_q && !started_q) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_WRST: begin
               widx_q  <= W_LINK;
               state_q <= dis_pend_q ? ST_IDLE : ST_FETCH;
            end
            ST_STALL: begin
               if (dis_pend_q) state_q <= ST_IDLE;
               else if (rel_pend_q) begin
                  widx_q  <= W_LINK;
                  state_q <= ST_FETCH;
               end
            end
            ST_DRAIN: begin
               if (s_valid && s_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xtr_mem_port.sv
module xtr_mem_port #(
   parameter int AW    = 16,
   parameter int LANES = 4
) (
   input  logic               rd_req,
   input  logic [AW-1:0]      rd_addr,
   input  logic               wr_byte,
   input  logic               wr_word,
   input  logic [AW-1:0]      wr_addr,
   input  logic [7:0]         wr_data8,
   input  logic [8*LANES-1:0] wr_data32,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [LANES-1:0]   mem_be,
   output logic [8*LANES-1:0] mem_wdata
);
   localparam int SEL_W = $clog2(LANES);

   assign mem_req  = rd_req | wr_byte | wr_word;
   assign mem_we   = wr_byte | wr_word;
   assign mem_addr = rd_req ? rd_addr : wr_addr;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mem_be[g] = wr_word | (wr_byte && (wr_addr[SEL_W-1:0] == SEL_W'(g)));
      assign mem_wdata[8*g +: 8] = wr_word ? wr_data32[8*g +: 8] : wr_data8;
   end
endmodule

// File: rtl/xtr_irq_regs.sv
module xtr_irq_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_done,
   input  logic blk_irq,
   input  logic blk_trunc,
   input  logic int_en,
   input  logic int_ack,
   input  logic err_ack,
   output logic irq_db,
   output logic irq_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_db  <= 1'b0;
         irq_err <= 1'b0;
      end else begin
         if (blk_done && blk_irq && int_en) irq_db <= 1'b1;
         else if (int_ack)                  irq_db <= 1'b0;
         if (blk_done && blk_trunc)         irq_err <= 1'b1;
         else if (err_ack)                  irq_err <= 1'b0;
      end
   end
endmodule

// File: rtl/xtr_dma_chan.sv
module xtr_dma_chan
   import xtr_dma_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] head_addr,
   input  logic          cmd_activate,
   input  logic          cmd_reload,
   input  logic          cmd_disable,
   input  logic          cmd_discard,
   input  logic          int_en,
   input  logic          int_ack,
   input  logic          err_ack,
   input  logic          s_valid,
   input  logic [7:0]    s_data,
   input  logic          s_last,
   output logic          s_ready,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          chan_active,
   output logic          irq_db,
   output logic          irq_err
);
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("xtr_dma_chan: AW must lie in 8..32");
   end

   logic             rd_req, wr_byte, wr_word, stalled;
   logic             blk_done, blk_irq, blk_trunc;
   logic [AW-1:0]    rd_addr, wr_addr, dptr_q;
   logic [7:0]       wr_data8;
   logic [31:0]      wr_data32;
   logic [LEN_W-1:0] cap_q;

   xtr_desc_ctrl #(.AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .head_addr(head_addr),
      .cmd_activate(cmd_activate), .cmd_reload(cmd_reload),
      .cmd_disable(cmd_disable), .cmd_discard(cmd_discard),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .rd_data(mem_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
      .wr_byte(wr_byte), .wr_word(wr_word), .wr_addr(wr_addr),
      .wr_data8(wr_data8), .wr_data32(wr_data32),
      .chan_active(chan_active), .stalled(stalled),
      .blk_done(blk_done), .blk_irq(blk_irq), .blk_trunc(blk_trunc),
      .dptr_q(dptr_q), .cap_q(cap_q)
   );

   xtr_mem_port #(.AW(AW), .LANES(4)) u_port (
      .rd_req(rd_req), .rd_addr(rd_addr), .wr_byte(wr_byte), .wr_word(wr_word),
      .wr_addr(wr_addr), .wr_data8(wr_data8), .wr_data32(wr_data32),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata)
   );

   xtr_irq_regs u_irq (
      .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .blk_irq(blk_irq),
      .blk_trunc(blk_trunc), .int_en(int_en), .int_ack(int_ack),
      .err_ack(err_ack), .irq_db(irq_db), .irq_err(irq_err)
   );
endmodule

// File: rtl/xtr_dma_chk.sv
module xtr_dma_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          chan_active,
   input logic          mem_req,
   input logic          mem_we,
   input logic [3:0]    mem_be,
   input logic [AW-1:0] mem_addr,
   input logic          s_ready,
   input logic          stalled,
   input logic [AW-1:0] dptr_q,
   input logic [15:0]   cap_q,
   input logic          irq_db,
   input logic          irq_err,
   input logic          int_ack,
   input logic          err_ack
);
   logic [31:0] off32, cap32;
   assign off32 = 32'(mem_addr - dptr_q);
   assign cap32 = 32'(cap_q);

   // R2: a single-byte write always falls inside the buffer capacity
   a_r2_wr_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be != 4'hF) |-> (off32 < cap32));

   // R5: a stalled channel neither accepts bytes nor touches memory
   a_r5_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> (!s_ready && !mem_req));

   // R7: no memory access while inactive
   a_r7_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_active |-> !mem_req);

   // R6: completion flag holds until acknowledged
   a_r6_db_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_db && !int_ack) |=> irq_db);

   // R4: truncation flag holds until acknowledged
   a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_err && !err_ack) |=> irq_err);
endmodule

bind xtr_dma_chan xtr_dma_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .mem_req(mem_req),
   .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .s_ready(s_ready),
   .stalled(stalled), .dptr_q(dptr_q), .cap_q(cap_q), .irq_db(irq_db),
   .irq_err(irq_err), .int_ack(int_ack), .err_ack(err_ack)
);

// File: tb/tb_xtr_dma_chan.sv
`timescale 1ns/1ps
module tb_xtr_dma_chan;
   localparam int AW = 16;
   localparam int CAP = 8;
   localparam logic [31:0] IRQ_ONLY = 32'h0004_0000;
   localparam logic [31:0] DONE_ALL = 32'h000F_0000;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] head_addr = '0;
   logic cmd_activate = 0, cmd_reload = 0, cmd_disable = 0, cmd_discard = 0;
   logic int_en = 0, int_ack = 0, err_ack = 0;
   logic s_valid = 0, s_last = 0;
   logic [7:0] s_data = '0;
   logic s_ready, mem_req, mem_we, chan_active, irq_db, irq_err;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;

   int tests = 0, fails = 0, wr_count = 0;

   xtr_dma_chan #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .head_addr(head_addr),
      .cmd_activate(cmd_activate), .cmd_reload(cmd_reload),
      .cmd_disable(cmd_disable), .cmd_discard(cmd_discard),
      .int_en(int_en), .int_ack(int_ack), .err_ack(err_ack),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .chan_active(chan_active), .irq_db(irq_db), .irq_err(irq_err)
   );

   logic [7:0] mem [0:1023];

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         wr_count = wr_count + 1;
         for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[{mem_addr[9:2], 2'(l)}] = mem_wdata[8*l +: 8];
      end else if (mem_req) begin
         mem_rdata <= {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                       mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};
      end
   end

   function automatic void wr32(int a, logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
   endfunction

   function automatic logic [31:0] rd32(int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send_bytes(int first, int n, int base, bit end_frame);
      for (int i = 0; i < n; i++) begin
         s_valid = 1'b1;
         s_data  = 8'(base + first + i);
         s_last  = end_frame && (i == n - 1);
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic wait_done(int sa);
      for (int t = 0; t < 200; t++) begin
         logic [31:0] w;
         @(negedge clk);
         w = rd32(sa);
         if (w[19]) break;
      end
   endtask

   task automatic pulse_reload();
      cmd_reload = 1'b1; @(negedge clk); cmd_reload = 1'b0;
   endtask

   task automatic ack_all();
      int_ack = 1'b1; err_ack = 1'b1; @(negedge clk);
      int_ack = 1'b0; err_ack = 1'b0;
   endtask

   task automatic fill(int a, int n);
      for (int i = 0; i < n; i++) mem[a + i] = 8'hEE;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!chan_active && !s_ready && !mem_req && !irq_db && !irq_err, "R9",
          {chan_active, s_ready, mem_req, irq_db, irq_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // ring of two descriptors: D0 at 0x000 (buf 0x100), D1 at 0x010 (buf 0x140)
      wr32(0,  32'h10); wr32(4,  CAP); wr32(8,  32'h100); wr32(12, IRQ_ONLY);
      wr32(16, 32'h1);  wr32(20, CAP); wr32(24, 32'h140); wr32(28, IRQ_ONLY);
      int_en = 1'b1;
      head_addr = '0;
      cmd_activate = 1'b1; @(negedge clk); cmd_activate = 1'b0;
      chk(chan_active, "R7", chan_active, 1);

      // sweep frame lengths across the capacity boundary
      for (int k = 1; k <= 12; k++) begin
         int cur, bufa, oth, n;
         bit ok;
         cur  = (k % 2 == 1) ? 0 : 16;
         oth  = (k % 2 == 1) ? 16 : 0;
         bufa = (k % 2 == 1) ? 'h100 : 'h140;
         n    = (k < CAP) ? k : CAP;
         fill(bufa, 12);
         send_bytes(0, k, k * 16, 1'b1);
         wait_done(cur + 12);
         repeat (2) @(negedge clk);
         chk(rd32(cur + 12) == (DONE_ALL | 32'(n)), "R3", rd32(cur + 12), DONE_ALL | 32'(n));
         ok = 1'b1;
         for (int i = 0; i < n; i++) if (mem[bufa + i] != 8'(k * 16 + i)) ok = 1'b0;
         if (k == 1) chk(ok, "R1", ok, 1);
         else        chk(ok, "R2", ok, 1);
         ok = 1'b1;
         for (int i = n; i < 12; i++) if (mem[bufa + i] != 8'hEE) ok = 1'b0;
         if (k > CAP) chk(ok, "R4", ok, 1);
         else         chk(ok, "R2", ok, 1);
         chk(irq_db == 1'b1, "R6", irq_db, 1);
         chk(irq_err == (k > CAP), "R4", irq_err, k > CAP);
         ack_all();
         chk(!irq_db && !irq_err, "R6", {irq_db, irq_err}, 0);
         // recycle the finished descriptor and append it behind the other one
         wr32(cur + 12, IRQ_ONLY);
         wr32(cur, 32'h1);
         if (k < 12) wr32(oth, 32'(cur));
         pulse_reload();
      end

      // frame 13 lands in D0, whose link is 0x1: the early reload is consumed
      fill('h100, 12);
      send_bytes(0, 4, 'hA0, 1'b1);
      wait_done(12);
      chk(rd32(12) == (DONE_ALL | 32'd4), "R3", rd32(12), DONE_ALL | 32'd4);
      ack_all();
      int_en = 1'b0;
      s_valid = 1'b1; s_data = 8'h55; s_last = 1'b0;
      repeat (10) @(negedge clk);
      chk(!s_ready, "R5", s_ready, 0);
      chk(rd32(28) == IRQ_ONLY, "R5", rd32(28), IRQ_ONLY);
      chk(chan_active, "R7", chan_active, 1);
      wr32(0, 32'h10);
      pulse_reload();
      fill('h140, 12);
      send_bytes(0, 3, 'h55, 1'b1);
      wait_done(28);
      repeat (2) @(negedge clk);
      chk(rd32(28) == (DONE_ALL | 32'd3), "R5", rd32(28), DONE_ALL | 32'd3);
      chk(mem['h142] == 8'h57, "R5", mem['h142], 8'h57);
      chk(!irq_db, "R6", irq_db, 0);
      int_en = 1'b1;

      // disable in the middle of a frame
      wr32(12, IRQ_ONLY); wr32(0, 32'h1); wr32(16, 32'h0);
      fill('h100, 12);
      pulse_reload();
      send_bytes(0, 2, 'h30, 1'b0);
      cmd_disable = 1'b1; @(negedge clk); cmd_disable = 1'b0;
      repeat (3) @(negedge clk);
      chk(chan_active, "R7", chan_active, 1);
      send_bytes(2, 3, 'h30, 1'b1);
      wait_done(12);
      chk(rd32(12) == (DONE_ALL | 32'd5), "R7", rd32(12), DONE_ALL | 32'd5);
      repeat (2) @(negedge clk);
      chk(!chan_active && !s_ready, "R7", {chan_active, s_ready}, 0);
      ack_all();

      // discard one frame while inactive
      begin
         int w0;
         w0 = wr_count;
         cmd_discard = 1'b1; @(negedge clk); cmd_discard = 1'b0;
         chk(s_ready, "R8", s_ready, 1);
         send_bytes(0, 3, 'h77, 1'b1);
         chk(!s_ready && !chan_active, "R8", {s_ready, chan_active}, 0);
         chk(wr_count == w0, "R8", wr_count, w0);
         chk(mem['h100] == 8'h30, "R8", mem['h100], 8'h30);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule